// File: doc/BRIEF.md
# Crosswise Digit-Column Multiplier

This block multiplies two unsigned 16-bit operands and returns their 32-bit product. Each operand is split into four 4-bit digits. Every digit of one operand is multiplied by every digit of the other, and all sixteen digit products are formed at the same time. The products are then gathered into seven columns. Column k holds the sum of every product whose two digit indices add up to k. Each column sum is scaled by 16 to the power k, and the scaled sums are added with full carry propagation to give the product.

A caller presents the operands together with a one-cycle `valid_in` strobe. On the next clock edge the product is captured into an output register, and `valid_out` rises for one cycle. When the strobe is low the register keeps its last product, so operand changes while idle are not seen at the output.

Top module: `vcm_mult16`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `valid_out` to 0 and `prod_out` to 0 at that edge.
- R2: When `valid_in` is 1 at a rising edge, `prod_out` equals the unsigned product `op_a * op_b` of the operands sampled at that edge, from that edge onward.
- R3: `valid_out` is 1 exactly in the cycle after a cycle in which `valid_in` was 1, and 0 otherwise.
- R4: When `valid_in` is 0 at a rising edge, `prod_out` keeps its previous value, whatever the operands hold.
- R5: If either operand is 0, the captured product is 0.
- R6: The operands 0xFFFF and 0xFFFF give 0xFFFE0001, so carries out of every column reach the top product digit.
- R7: Digit weighting follows position: digit i of `op_a` (bits 4i+3..4i) times digit j of `op_b` contributes to product column i+j with weight 16^(i+j). For example 0x1000 x 0x1000 gives 0x01000000 (column 6 only), and 0x0001 x 0x0001 gives 1 (column 0 only).
- R8: Column 3 sums four crosswise terms. The operands 0x1111 x 0x1111 give 0x01234321: each product digit k is the number of terms in column k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operands are valid this cycle |
| op_a | input | 16 | Multiplicand, unsigned |
| op_b | input | 16 | Multiplier, unsigned |
| prod_out | output | 32 | Registered unsigned product |
| valid_out | output | 1 | Product register was loaded last edge |

## Verification
Several properties are checked on every cycle. The strobe is delayed by one cycle, the product holds while idle, the register is cleared under reset, a zero operand gives zero, and the registered product matches a plain multiplication of the operands sampled the cycle before. The bench scenarios show that the column arrangement itself is right. Walking single digits exposes each column weight. Repeating-digit operands expose column sums that run over a digit boundary. The all-ones pair checks the full carry chain into the top digit.

// File: rtl/vcm_pkg.sv
// Package: shared sizing for the crosswise digit-column multiplier.
// Assumes operands are a whole number of digits wide.
package vcm_pkg;
    localparam int VCM_DIGIT_W    = 4;
    localparam int VCM_NUM_DIGITS = 4;

    // Bits needed for a column holding up to n_terms digit products.
    function automatic int colsum_width(input int digit_w, input int n_terms);
        return 2 * digit_w + $clog2(n_terms + 1);
    endfunction
endpackage

// File: rtl/vcm_digit_mult.sv
// Module: vcm_digit_mult
// Multiplies one digit by another, unsigned and purely combinational.
// Assumes nothing about the operands beyond their width.
module vcm_digit_mult #(
    parameter int DIGIT_W = 4,
    localparam int PP_W   = 2 * DIGIT_W
) (
    input  logic [DIGIT_W-1:0] dig_x,
    input  logic [DIGIT_W-1:0] dig_y,
    output logic [PP_W-1:0]    pp
);
    // Widen both digits before the multiply so no bit of the product is lost.
    always_comb begin
        pp = PP_W'(dig_x) * PP_W'(dig_y);
    end
endmodule

// File: rtl/vcm_column_sum.sv
// Module: vcm_column_sum
// Adds the digit products that fall in one product column.
// Assumes slots that carry no product for this column are tied to zero.
module vcm_column_sum #(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 4,
    localparam int PP_W      = 2 * DIGIT_W,
    localparam int CS_W      = vcm_pkg::colsum_width(DIGIT_W, NUM_DIGITS)
) (
    input  logic [NUM_DIGITS*PP_W-1:0] terms,
    output logic [CS_W-1:0]            col_sum
);
    // Sum every slot of the column in one adder tree.
    always_comb begin
        col_sum = '0;
        for (int s = 0; s < NUM_DIGITS; s++) begin
            col_sum = col_sum + CS_W'(terms[s*PP_W +: PP_W]);
        end
    end
endmodule

// File: rtl/vcm_merge.sv
// Module: vcm_merge
// Weights each column sum by its digit position and adds them with carries.
// Assumes the true product fits in PROD_W bits, so bits shifted out are zero.
module vcm_merge #(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 4,
    localparam int NUM_COLS  = 2 * NUM_DIGITS - 1,
    localparam int CS_W      = vcm_pkg::colsum_width(DIGIT_W, NUM_DIGITS),
    localparam int PROD_W    = 2 * DIGIT_W * NUM_DIGITS
) (
    input  logic [NUM_COLS*CS_W-1:0] col_flat,
    output logic [PROD_W-1:0]        product
);
    // Shift column k up by k digits and add it to the running result.
    always_comb begin
        product = '0;
        for (int k = 0; k < NUM_COLS; k++) begin
            product = product + (PROD_W'(col_flat[k*CS_W +: CS_W]) << (DIGIT_W * k));
        end
    end
endmodule

// File: rtl/vcm_mult16.sv
// Module: vcm_mult16
// Unsigned multiplier built from parallel crosswise digit columns. The
// product goes into a register that loads only when valid_in is set.
// Assumes unsigned operands and a synchronous active-low reset.
module vcm_mult16 #(
    parameter int DIGIT_W    = vcm_pkg::VCM_DIGIT_W,
    parameter int NUM_DIGITS = vcm_pkg::VCM_NUM_DIGITS,
    localparam int OP_W      = DIGIT_W * NUM_DIGITS,
    localparam int PROD_W    = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] prod_out,
    output logic              valid_out
);
    localparam int PP_W     = 2 * DIGIT_W;
    localparam int NUM_COLS = 2 * NUM_DIGITS - 1;
    localparam int CS_W     = vcm_pkg::colsum_width(DIGIT_W, NUM_DIGITS);

    logic [DIGIT_W-1:0]         a_dig [NUM_DIGITS];
    logic [DIGIT_W-1:0]         b_dig [NUM_DIGITS];
    logic [PP_W-1:0]            pp    [NUM_DIGITS][NUM_DIGITS];
    logic [NUM_DIGITS*PP_W-1:0] col_terms [NUM_COLS];
    logic [NUM_COLS*CS_W-1:0]   col_flat;
    logic [PROD_W-1:0]          prod_comb;
    logic [PROD_W-1:0]          prod_q;
    logic                       valid_q;

    // Cut both operands into digits.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_split
        assign a_dig[g] = op_a[g*DIGIT_W +: DIGIT_W];
        assign b_dig[g] = op_b[g*DIGIT_W +: DIGIT_W];
    end

    // Form all digit products at once.
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_row
        for (genvar j = 0; j < NUM_DIGITS; j++) begin : g_cell
            vcm_digit_mult #(.DIGIT_W(DIGIT_W)) i_dm (
                .dig_x (a_dig[i]),
                .dig_y (b_dig[j]),
                .pp    (pp[i][j])
            );
        end
    end

    // Route the product of (i, k-i) into slot i of column k; unused slots get zero.
    for (genvar k = 0; k < NUM_COLS; k++) begin : g_col
        for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_slot
            if ((k - i) >= 0 && (k - i) < NUM_DIGITS) begin : g_used
                assign col_terms[k][i*PP_W +: PP_W] = pp[i][k-i];
            end else begin : g_empty
                assign col_terms[k][i*PP_W +: PP_W] = '0;
            end
        end
        vcm_column_sum #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) i_cs (
            .terms   (col_terms[k]),
            .col_sum (col_flat[k*CS_W +: CS_W])
        );
    end

    // Weight and add the column sums.
    vcm_merge #(.DIGIT_W(DIGIT_W), .NUM_DIGITS(NUM_DIGITS)) i_merge (
        .col_flat (col_flat),
        .product  (prod_comb)
    );

    // Load the product on a valid strobe; pass the strobe through one stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_in;
            if (valid_in) begin
                prod_q <= prod_comb;
            end
        end
    end

    assign prod_out  = prod_q;
    assign valid_out = valid_q;
endmodule

// File: rtl/vcm_mult16_chk.sv
// Module: vcm_mult16_chk
// Port-level properties of the multiplier, attached to it with bind.
// Assumes the same default widths as the multiplier.
module vcm_mult16_chk #(
    parameter int OP_W   = 16,
    parameter int PROD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic [PROD_W-1:0] prod_out,
    input logic              valid_out
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (valid_out == 1'b0 && prod_out == '0)); // R1
    AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> prod_out == (PROD_W'($past(op_a)) * PROD_W'($past(op_b)))); // R2
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) valid_in |=> valid_out); // R3
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !valid_in |=> !valid_out); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !valid_in |=> $stable(prod_out)); // R4
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && (op_a == '0 || op_b == '0)) |=> prod_out == '0); // R5
endmodule

bind vcm_mult16 vcm_mult16_chk i_chk (.*);

// File: tb/test_vcm_mult16.sv
// Directed bench for vcm_mult16: one task per scenario, each checking itself.
module test_vcm_mult16;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] prod_out;
    logic        valid_out;

    int n_checks = 0;
    int n_bad    = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    vcm_mult16 i_vcm_mult16 (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .op_a(op_a), .op_b(op_b), .prod_out(prod_out), .valid_out(valid_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one pair for one cycle; check the product and strobe one edge later.
    task automatic mul_once(input string req, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_a = a; op_b = b; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        check(req, prod_out, 32'(a) * 32'(b));
        check("R3 strobe high", {31'd0, valid_out}, 32'd1);
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 product", prod_out, 32'd0);
        check("R1 valid", {31'd0, valid_out}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_corners();
        mul_once("R5 zero a", 16'h0000, 16'hBEEF);
        mul_once("R5 zero b", 16'h1234, 16'h0000);
        mul_once("R2 one", 16'h0001, 16'hABCD);
        mul_once("R6 all ones", 16'hFFFF, 16'hFFFF);
        check("R6 literal", prod_out, 32'hFFFE0001);
    endtask

    task automatic t_columns();
        mul_once("R7 col0", 16'h0001, 16'h0001);
        check("R7 col0 literal", prod_out, 32'h00000001);
        mul_once("R7 col6", 16'h1000, 16'h1000);
        check("R7 col6 literal", prod_out, 32'h01000000);
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                mul_once("R7 digit walk", 16'(16'h0009 << (4*i)), 16'(16'h000E << (4*j)));
            end
        end
        mul_once("R8 four-term column", 16'h1111, 16'h1111);
        check("R8 literal", prod_out, 32'h01234321);
    endtask

    // Idle cycles with changing operands must not disturb the output.
    task automatic t_hold();
        logic [31:0] held;
        mul_once("R2 before hold", 16'h7A5C, 16'h3E91);
        held = prod_out;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            op_a = 16'(16'h1357 * (c + 2)); op_b = 16'(16'hFEDC - c);
            @(negedge clk);
            check("R4 held product", prod_out, held);
            check("R3 strobe low", {31'd0, valid_out}, 32'd0);
        end
    endtask

    // Back-to-back strobes: each edge takes a new pair.
    task automatic t_random();
        int unsigned seed = 32'd7;
        logic [15:0] a;
        logic [15:0] b;
        for (int n = 0; n < 60; n++) begin
            a = 16'($urandom(seed)); b = 16'($urandom(seed + n));
            seed = seed + 13;
            @(negedge clk);
            op_a = a; op_b = b; valid_in = 1'b1;
            @(negedge clk);
            check("R2 random", prod_out, 32'(a) * 32'(b));
            check("R3 strobe stream", {31'd0, valid_out}, 32'd1);
        end
        valid_in = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_corners();
        t_columns();
        t_hold();
        t_random();
        t_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule